// File: doc/BRIEF.md
# Flash Block Protection Gate

This block decides whether a request to turn on the high-voltage enable for a flash program or erase step may take effect. It holds an 8-bit protect register. The register value sets where a protected window begins. That window always extends to the highest address of a 16-bit flash map. A program or page-erase aimed at an address inside the window is refused. A mass erase is refused whenever any part of the array is protected. Each refusal leaves the high-voltage enable unchanged and raises a sticky violation flag.

The protect register locks itself as soon as it holds any value other than 0xFF. While it is locked, it can be rewritten or erased only when the test-high-voltage input is asserted. A write or erase attempted without that input is dropped and also raises the violation flag. There is no data stream through this block, so every pin is a plain level or single-cycle strobe sampled on the rising clock edge. All outputs are registered and change on the edge that follows the stimulus.

Top module: `flash_prot_gate`

## Requirements
- R1: After reset the protect register reads 0xFF, and both `hven` and `prot_viol` are 0.
- R2: The operation code `op_sel` is 0 for none, 1 for program, 2 for page erase and 3 for mass erase. For program or page erase with a register value P other than 0xFF, a set request to an address at or above {P, 8'h00} is refused: `hven` stays 0, and `prot_viol` is 1 on the next edge.
- R3: With the register at 0xFF, a set request for any operation code 1 to 3 and any address sets `hven` on the next edge and leaves `prot_viol` at 0.
- R4: With the register at 0x00, every program or page-erase set request is refused, whatever the address.
- R5: A mass-erase set request is refused whenever the register differs from 0xFF, whatever the address.
- R6: A register write while the register holds 0xFF is taken on the next edge, with or without the test voltage.
- R7: While the register differs from 0xFF and `test_hv` is 0, a register write or erase is dropped, the register is unchanged, and `prot_viol` becomes 1.
- R8: While `test_hv` is 1, register writes and erases are always taken. An erase sets the register to 0xFF and takes priority over a write in the same cycle.
- R9: `prot_viol` stays set until a cycle with `viol_clr` high. A new violation in that same cycle keeps it set.
- R10: A request with `hven_wr_val` 0 clears `hven`. A set request with `op_sel` 0 is ignored and raises no violation.
- R11: For program or page erase with a register value P other than 0xFF, a set request to an address below {P, 8'h00} is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 2 | Current operation: 0 none, 1 program, 2 page erase, 3 mass erase |
| tgt_addr | input | 16 | Flash address targeted by the operation |
| hven_wr_en | input | 1 | Strobe: write `hven_wr_val` to the high-voltage enable |
| hven_wr_val | input | 1 | Requested value of the high-voltage enable |
| test_hv | input | 1 | Test high voltage present; unlocks the protect register |
| preg_wr_en | input | 1 | Strobe: write `preg_wr_data` to the protect register |
| preg_wr_data | input | 8 | New protect register value |
| preg_erase | input | 1 | Strobe: erase the protect register to 0xFF |
| viol_clr | input | 1 | Write-one-to-clear for the violation flag |
| preg_q | output | 8 | Current protect register value |
| hven | output | 1 | Granted high-voltage enable |
| prot_viol | output | 1 | Sticky protection-violation flag |

## Verification
A wrong protect register value shows on `preg_q` one edge after the write that produced it. It also changes which addresses are refused, so `hven` and `prot_viol` differ from the expected result on the first set request near the window boundary. A bad lock state appears one edge after a register write made without the test voltage: either the register changes when it should not, or the violation flag fails to rise. A stuck violation flag or a stuck enable shows one edge after the next clear or set request. The sweep covers every register value, with addresses on both sides of each window start.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_PAGE  = 2'd2,
    OP_MASS  = 2'd3
  } flash_op_e;
endpackage

// File: rtl/prot_window_cmp.sv
module prot_window_cmp #(
  parameter int ADDR_W = 16,
  parameter int PROT_W = 8
) (
  input  logic [PROT_W-1:0] preg,
  input  logic [ADDR_W-1:0] addr,
  output logic              open_all,
  output logic              in_window
);
  localparam int LOW_W = ADDR_W - PROT_W;

  logic [ADDR_W-1:0] start_addr;

  always_comb begin
    open_all   = &preg;
    start_addr = {preg, {LOW_W{1'b0}}};
    in_window  = !open_all && (addr >= start_addr);
  end
endmodule

// File: rtl/preg_ctrl.sv
module preg_ctrl #(
  parameter int PROT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PROT_W-1:0] wr_data,
  input  logic              erase,
  input  logic              test_hv,
  output logic [PROT_W-1:0] preg_q,
  output logic              locked,
  output logic              drop
);
  localparam logic [PROT_W-1:0] OPEN_VAL = {PROT_W{1'b1}};

  logic allow;
  logic touch;

  always_comb begin
    locked = (preg_q != OPEN_VAL);
    allow  = !locked || test_hv;
    touch  = wr_en || erase;
    drop   = touch && !allow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preg_q <= OPEN_VAL;
    end else if (touch && allow) begin
      if (erase) preg_q <= OPEN_VAL;
      else       preg_q <= wr_data;
    end
  end
endmodule

// File: rtl/hven_gate.sv
module hven_gate
  import flash_prot_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flash_op_e op,
  input  logic      req_en,
  input  logic      req_val,
  input  logic      locked,
  input  logic      in_window,
  input  logic      reg_drop,
  input  logic      viol_clr,
  output logic      hven,
  output logic      viol
);
  logic blocked;
  logic set_req;
  logic refuse;
  logic grant;

  always_comb begin
    blocked = (op == OP_MASS) ? locked : in_window;
    set_req = req_en && req_val && (op != OP_NONE);
    refuse  = set_req && blocked;
    grant   = set_req && !blocked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hven <= 1'b0;
    end else if (req_en && !req_val) begin
      hven <= 1'b0;
    end else if (grant) begin
      hven <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol <= 1'b0;
    end else if (refuse || reg_drop) begin
      viol <= 1'b1;
    end else if (viol_clr) begin
      viol <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_prot_gate.sv
module flash_prot_gate
  import flash_prot_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PROT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_sel,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic              hven_wr_en,
  input  logic              hven_wr_val,
  input  logic              test_hv,
  input  logic              preg_wr_en,
  input  logic [PROT_W-1:0] preg_wr_data,
  input  logic              preg_erase,
  input  logic              viol_clr,
  output logic [PROT_W-1:0] preg_q,
  output logic              hven,
  output logic              prot_viol
);
  logic      locked;
  logic      reg_drop;
  logic      open_all;
  logic      in_window;
  flash_op_e op;

  assign op = flash_op_e'(op_sel);

  preg_ctrl #(.PROT_W(PROT_W)) u_preg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (preg_wr_en),
    .wr_data (preg_wr_data),
    .erase   (preg_erase),
    .test_hv (test_hv),
    .preg_q  (preg_q),
    .locked  (locked),
    .drop    (reg_drop)
  );

  prot_window_cmp #(.ADDR_W(ADDR_W), .PROT_W(PROT_W)) u_cmp (
    .preg      (preg_q),
    .addr      (tgt_addr),
    .open_all  (open_all),
    .in_window (in_window)
  );

  hven_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .req_en    (hven_wr_en),
    .req_val   (hven_wr_val),
    .locked    (locked),
    .in_window (in_window),
    .reg_drop  (reg_drop),
    .viol_clr  (viol_clr),
    .hven      (hven),
    .viol      (prot_viol)
  );
endmodule

// File: rtl/flash_prot_gate_chk.sv
module flash_prot_gate_chk #(
  parameter int ADDR_W = 16,
  parameter int PROT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        op_sel,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic              hven_wr_en,
  input logic              hven_wr_val,
  input logic              test_hv,
  input logic              preg_wr_en,
  input logic              preg_erase,
  input logic              viol_clr,
  input logic [PROT_W-1:0] preg_q,
  input logic              hven,
  input logic              prot_viol
);
  localparam logic [PROT_W-1:0] OPEN_VAL = {PROT_W{1'b1}};

  // R5
  mass_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hven) |-> ($past(op_sel) != 2'd3 || $past(preg_q) == OPEN_VAL));

  // R5
  mass_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hven_wr_en && hven_wr_val && op_sel == 2'd3 && preg_q != OPEN_VAL) |=> prot_viol);

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (preg_q != OPEN_VAL && !test_hv) |=> $stable(preg_q));

  // R7
  lock_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (preg_q != OPEN_VAL && !test_hv && (preg_wr_en || preg_erase)) |=> prot_viol);

  // R9
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_viol && !viol_clr) |=> prot_viol);

  // R10
  hven_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hven_wr_en && !hven_wr_val) |=> !hven);

  // R8
  erase_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (preg_erase && test_hv) |=> (preg_q == OPEN_VAL));
endmodule

bind flash_prot_gate flash_prot_gate_chk #(.ADDR_W(ADDR_W), .PROT_W(PROT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_sel      (op_sel),
  .tgt_addr    (tgt_addr),
  .hven_wr_en  (hven_wr_en),
  .hven_wr_val (hven_wr_val),
  .test_hv     (test_hv),
  .preg_wr_en  (preg_wr_en),
  .preg_erase  (preg_erase),
  .viol_clr    (viol_clr),
  .preg_q      (preg_q),
  .hven        (hven),
  .prot_viol   (prot_viol)
);

// File: tb/test_flash_prot_gate.sv
`timescale 1ns/1ps
module test_flash_prot_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_sel = 2'd0;
  logic [15:0] tgt_addr = 16'h0;
  logic        hven_wr_en = 1'b0;
  logic        hven_wr_val = 1'b0;
  logic        test_hv = 1'b0;
  logic        preg_wr_en = 1'b0;
  logic [7:0]  preg_wr_data = 8'h0;
  logic        preg_erase = 1'b0;
  logic        viol_clr = 1'b0;
  logic [7:0]  preg_q;
  logic        hven;
  logic        prot_viol;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_prot_gate i_flash_prot_gate (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .tgt_addr(tgt_addr),
    .hven_wr_en(hven_wr_en), .hven_wr_val(hven_wr_val), .test_hv(test_hv),
    .preg_wr_en(preg_wr_en), .preg_wr_data(preg_wr_data), .preg_erase(preg_erase),
    .viol_clr(viol_clr), .preg_q(preg_q), .hven(hven), .prot_viol(prot_viol)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    hven_wr_en = 1'b0; preg_wr_en = 1'b0; preg_erase = 1'b0; viol_clr = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] v);
    test_hv = 1'b1; preg_wr_en = 1'b1; preg_wr_data = v;
    step();
    test_hv = 1'b0;
  endtask

  task automatic clean();
    hven_wr_en = 1'b1; hven_wr_val = 1'b0; viol_clr = 1'b1;
    step();
  endtask

  // one set request after a clean state; expectation computed from the register value
  task automatic trial(input logic [7:0] p, input logic [1:0] op, input logic [15:0] a);
    bit ok;
    string req;
    clean();
    if (op == 2'd3) begin
      ok = (p == 8'hFF);
      req = (p == 8'hFF) ? "R3" : "R5";
    end else begin
      ok = (p == 8'hFF) || (a < {p, 8'h00});
      if (p == 8'hFF)      req = "R3";
      else if (p == 8'h00) req = "R4";
      else if (ok)         req = "R11";
      else                 req = "R2";
    end
    op_sel = op; tgt_addr = a; hven_wr_en = 1'b1; hven_wr_val = 1'b1;
    step();
    chk(req, hven, ok);
    chk(req, prot_viol, !ok);
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #7;
    chk("R1", preg_q, 8'hFF);
    chk("R1", hven, 0);
    chk("R1", prot_viol, 0);
    rst_n = 1'b1;
    step();

    // R10: no operation selected -> ignored, no violation
    op_sel = 2'd0; hven_wr_en = 1'b1; hven_wr_val = 1'b1;
    step();
    chk("R10", hven, 0);
    chk("R10", prot_viol, 0);

    // R6: unlocked write, no test voltage
    preg_wr_en = 1'b1; preg_wr_data = 8'h80;
    step();
    chk("R6", preg_q, 8'h80);

    // R8: erase wins over write under test voltage
    test_hv = 1'b1; preg_erase = 1'b1; preg_wr_en = 1'b1; preg_wr_data = 8'h10;
    step();
    test_hv = 1'b0;
    chk("R8", preg_q, 8'hFF);

    for (int p = 0; p < 256; p++) begin
      logic [7:0] pv;
      pv = p[7:0];
      set_reg(pv);
      chk("R8", preg_q, pv);
      for (int op = 1; op < 4; op++) begin
        trial(pv, op[1:0], 16'h0000);
        trial(pv, op[1:0], 16'hFFFF);
        trial(pv, op[1:0], {pv, 8'h00});
        trial(pv, op[1:0], {pv, 8'h7F});
        if (pv != 8'h00) trial(pv, op[1:0], {pv, 8'h00} - 16'd1);
      end
      // R10: clear request drops a granted enable
      if (pv != 8'h00 && pv != 8'hFF) begin
        clean();
        op_sel = 2'd1; tgt_addr = 16'h0000; hven_wr_en = 1'b1; hven_wr_val = 1'b1;
        step();
        chk("R11", hven, 1);
        hven_wr_en = 1'b1; hven_wr_val = 1'b0;
        step();
        chk("R10", hven, 0);
      end
      // R7: locked write and erase without test voltage are dropped
      if (pv != 8'hFF) begin
        clean();
        preg_wr_en = 1'b1; preg_wr_data = pv ^ 8'h01;
        step();
        chk("R7", preg_q, pv);
        chk("R7", prot_viol, 1);
        clean();
        preg_erase = 1'b1;
        step();
        chk("R7", preg_q, pv);
        chk("R7", prot_viol, 1);
        // R9: flag persists, then clears, then set wins over clear
        step();
        chk("R9", prot_viol, 1);
        viol_clr = 1'b1;
        step();
        chk("R9", prot_viol, 0);
        viol_clr = 1'b1; op_sel = 2'd3; hven_wr_en = 1'b1; hven_wr_val = 1'b1;
        step();
        chk("R9", prot_viol, 1);
        // R8: erase under test voltage unlocks
        test_hv = 1'b1; preg_erase = 1'b1;
        step();
        test_hv = 1'b0;
        chk("R8", preg_q, 8'hFF);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule